// File: doc/BRIEF.md
# Shared Interrupt Line Router

This block steers a small set of shared, level-sensitive device interrupt lines onto the inputs of a legacy interrupt controller. Each shared line has one byte-wide steering register. A value below the output count names the controller input that the line drives. Any larger value leaves the line unconnected. When several lines are steered to the same controller input, that input behaves as a wired-OR of them.

Internally the block keeps one level bit per (output, line) pair. A level change on a line rewrites only that line's bit at its current target. A write to any steering register clears the whole bit map and fills it again from the live line levels under the new steering. This keeps stale bits from a previous target from holding an output high.

A separate combinational helper gives the shared line that a device uses, from its device/function number and its interrupt pin. The slot is the device/function number shifted right by three. The pin index is 0 to 3 for the first to fourth pin.

Top module: `pirq_router`

## Requirements
- R1: After reset every steering register reads 0x80 and every bit of `irq_out` is 0.
- R2: A read of steering register n (n = 0..3, one per shared line in order) returns the full 8-bit value last written to it, including bit 7.
- R3: With steering register n holding a value t below 16 and line n high, bit t of `irq_out` is 1. `irq_out` changes on the clock edge that samples a new line level or a steering write, and only on that edge.
- R4: A steering value of 16 or more disconnects its line: raising or lowering that line leaves `irq_out` unchanged.
- R5: Output bit t is the OR of every line steered to t. It falls only after the last of those lines falls.
- R6: A steering write rebuilds the level map from the live levels. After a high line is re-steered from t1 to t2, bit t1 is 0 and bit t2 is 1 one clock after the write, even though the line level did not change.
- R7: A write to one steering register leaves the other three steering registers unchanged.
- R8: `slot_line` = (`slot_pin` + (`slot_devfn` >> 3) − 1) mod 4, for every device/function number and pin.
- R9: With no steering write and no line-level change for two cycles, `irq_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Steering register write strobe |
| cfg_idx | input | 2 | Steering register index for writes |
| cfg_wdata | input | 8 | Steering write data |
| cfg_rd_idx | input | 2 | Steering register index for reads |
| cfg_rdata | output | 8 | Steering read data (combinational) |
| pirq_lvl | input | 4 | Shared interrupt line levels, active high |
| irq_out | output | 16 | Controller input levels, registered |
| slot_devfn | input | 8 | Device/function number for slot lookup |
| slot_pin | input | 2 | Interrupt pin index for slot lookup |
| slot_line | output | 2 | Shared line used by that device pin |

## Verification
The hardest case to reach is a stale map bit. A line is high at one target, then it is re-steered while still high. A bit left behind at the old target would hold that output high, and no level change can show this. The bench therefore raises a line and keeps it high across a re-steering write. It then checks that the old output bit falls and the new one rises one clock after the write. It also steers all four lines to a single output and walks through every combination of levels, so that the OR sharing and the point at which the output releases are covered.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;
   localparam int ROUTE_W = 8;
   typedef logic [ROUTE_W-1:0] route_byte_t;
   localparam route_byte_t ROUTE_RST = 8'h80;

   function automatic logic route_live(input route_byte_t v, input int n_outs);
      return (int'(v) < n_outs);
   endfunction
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
   import pirq_router_pkg::*;
#(
   parameter int NUM_LINES = 4,
   localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic                              wr,
   input  logic [IDX_W-1:0]                  widx,
   input  route_byte_t                       wdata,
   input  logic [IDX_W-1:0]                  ridx,
   output route_byte_t                       rdata,
   output route_byte_t [NUM_LINES-1:0]       route_q,
   output route_byte_t [NUM_LINES-1:0]       route_nx,
   output logic                              touched
);
   always_comb begin
      route_nx = route_q;
      if (wr) route_nx[widx] = wdata;
   end

   assign touched = wr;
   assign rdata   = route_q[ridx];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NUM_LINES; i++) route_q[i] <= ROUTE_RST;
      end else begin
         route_q <= route_nx;
      end
   end
endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map
   import pirq_router_pkg::*;
#(
   parameter int NUM_LINES = 4,
   parameter int NUM_OUTS  = 16,
   localparam int MAP_W = NUM_LINES * NUM_OUTS
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         rebuild,
   input  route_byte_t [NUM_LINES-1:0]  route_nx,
   input  logic [NUM_LINES-1:0]         lvl,
   output logic [MAP_W-1:0]             map_q
);
   logic [MAP_W-1:0] map_d;

   always_comb begin
      map_d = rebuild ? '0 : map_q;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (route_live(route_nx[i], NUM_OUTS)) begin
            map_d[int'(route_nx[i]) * NUM_LINES + i] = lvl[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) map_q <= '0;
      else     map_q <= map_d;
   end
endmodule

// File: rtl/pirq_out_reduce.sv
module pirq_out_reduce #(
   parameter int NUM_LINES = 4,
   parameter int NUM_OUTS  = 16,
   localparam int MAP_W = NUM_LINES * NUM_OUTS
) (
   input  logic [MAP_W-1:0]    map_q,
   output logic [NUM_OUTS-1:0] irq
);
   for (genvar o = 0; o < NUM_OUTS; o++) begin : g_out
      assign irq[o] = |map_q[o*NUM_LINES +: NUM_LINES];
   end
endmodule

// File: rtl/pirq_slot_map.sv
module pirq_slot_map #(
   parameter int NUM_LINES = 4,
   parameter int DEVFN_W   = 8,
   parameter int FUNC_W    = 3,
   localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
   localparam int SLOT_W = DEVFN_W - FUNC_W
) (
   input  logic [DEVFN_W-1:0] devfn,
   input  logic [LINE_W-1:0]  pin,
   output logic [LINE_W-1:0]  line
);
   logic [SLOT_W-1:0] slot;
   logic [SLOT_W:0]   sum;

   assign slot = devfn[DEVFN_W-1:FUNC_W];
   assign sum  = (SLOT_W+1)'(pin) + (SLOT_W+1)'(slot) - (SLOT_W+1)'(1);
   assign line = sum[LINE_W-1:0];
endmodule

// File: rtl/pirq_router.sv
module pirq_router
   import pirq_router_pkg::*;
#(
   parameter int NUM_LINES = 4,
   parameter int NUM_OUTS  = 16,
   parameter int DEVFN_W   = 8,
   parameter int FUNC_W    = 3,
   localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
   localparam int MAP_W = NUM_LINES * NUM_OUTS
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 cfg_wr,
   input  logic [IDX_W-1:0]     cfg_idx,
   input  logic [ROUTE_W-1:0]   cfg_wdata,
   input  logic [IDX_W-1:0]     cfg_rd_idx,
   output logic [ROUTE_W-1:0]   cfg_rdata,
   input  logic [NUM_LINES-1:0] pirq_lvl,
   output logic [NUM_OUTS-1:0]  irq_out,
   input  logic [DEVFN_W-1:0]   slot_devfn,
   input  logic [IDX_W-1:0]     slot_pin,
   output logic [IDX_W-1:0]     slot_line
);
   if ((NUM_LINES < 2) || ((NUM_LINES & (NUM_LINES - 1)) != 0)) begin : g_bad_lines
      $error("NUM_LINES must be a power of two of at least 2");
   end
   if ((NUM_OUTS < 1) || (NUM_OUTS > (1 << ROUTE_W))) begin : g_bad_outs
      $error("NUM_OUTS must fit in a steering byte");
   end
   if (DEVFN_W <= FUNC_W) begin : g_bad_devfn
      $error("DEVFN_W must exceed FUNC_W");
   end

   route_byte_t [NUM_LINES-1:0] route_q;
   route_byte_t [NUM_LINES-1:0] route_nx;
   logic                        touched;
   logic [MAP_W-1:0]            map_q;

   pirq_route_regs #(.NUM_LINES(NUM_LINES)) u_regs (
      .clk(clk), .rst(rst), .wr(cfg_wr), .widx(cfg_idx), .wdata(cfg_wdata),
      .ridx(cfg_rd_idx), .rdata(cfg_rdata), .route_q(route_q),
      .route_nx(route_nx), .touched(touched)
   );

   pirq_level_map #(.NUM_LINES(NUM_LINES), .NUM_OUTS(NUM_OUTS)) u_map (
      .clk(clk), .rst(rst), .rebuild(touched), .route_nx(route_nx),
      .lvl(pirq_lvl), .map_q(map_q)
   );

   pirq_out_reduce #(.NUM_LINES(NUM_LINES), .NUM_OUTS(NUM_OUTS)) u_reduce (
      .map_q(map_q), .irq(irq_out)
   );

   pirq_slot_map #(.NUM_LINES(NUM_LINES), .DEVFN_W(DEVFN_W), .FUNC_W(FUNC_W)) u_slot (
      .devfn(slot_devfn), .pin(slot_pin), .line(slot_line)
   );
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
   import pirq_router_pkg::*;
#(
   parameter int NUM_LINES = 4,
   parameter int NUM_OUTS  = 16,
   parameter int DEVFN_W   = 8,
   parameter int FUNC_W    = 3,
   localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input logic                        clk,
   input logic                        rst,
   input logic                        wr,
   input logic [IDX_W-1:0]            widx,
   input logic [ROUTE_W-1:0]          wdata,
   input logic [NUM_LINES-1:0]        lvl,
   input route_byte_t [NUM_LINES-1:0] route,
   input logic [NUM_OUTS-1:0]         irq,
   input logic [DEVFN_W-1:0]          devfn,
   input logic [IDX_W-1:0]            pin,
   input logic [IDX_W-1:0]            line
);
   logic [NUM_OUTS-1:0] hit;
   logic                all_off;
   logic [1:0]          armed;

   always_comb begin
      hit     = '0;
      all_off = 1'b1;
      for (int i = 0; i < NUM_LINES; i++) begin
         route_byte_t nx;
         nx = (wr && (int'(widx) == i)) ? wdata : route[i];
         if (int'(nx) < NUM_OUTS) begin
            all_off = 1'b0;
            if (lvl[i]) hit[int'(nx)] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) armed <= '0;
      else if (armed != 2'd3) armed <= armed + 2'd1;
   end

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      p_readback_r2: assert property (@(posedge clk) disable iff (rst)
         (wr && (int'(widx) == i)) |=> (route[i] == $past(wdata)));
      p_keep_other_r7: assert property (@(posedge clk) disable iff (rst)
         (wr && (int'(widx) != i)) |=> $stable(route[i]));
      p_route_r3: assert property (@(posedge clk) disable iff (rst)
         (!wr && lvl[i] && (int'(route[i]) < NUM_OUTS)) |=> irq[int'(route[i])]);
   end

   p_wired_or_r5: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (irq == $past(hit)));

   p_disabled_r4: assert property (@(posedge clk) disable iff (rst)
      all_off |=> (irq == '0));

   p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      ((armed == 2'd3) && !wr && $stable(lvl) && !$past(wr)) |=> $stable(irq));

   p_slot_r8: assert property (@(posedge clk) disable iff (rst)
      line == IDX_W'(int'(pin) + int'(devfn >> FUNC_W) - 1));
endmodule

bind pirq_router pirq_router_chk #(
   .NUM_LINES(NUM_LINES), .NUM_OUTS(NUM_OUTS), .DEVFN_W(DEVFN_W), .FUNC_W(FUNC_W)
) u_chk (
   .clk(clk), .rst(rst), .wr(cfg_wr), .widx(cfg_idx), .wdata(cfg_wdata),
   .lvl(pirq_lvl), .route(route_q), .irq(irq_out), .devfn(slot_devfn),
   .pin(slot_pin), .line(slot_line)
);

// File: tb/pirq_router_test.sv
module pirq_router_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_idx = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [1:0]  cfg_rd_idx = '0;
   logic [7:0]  cfg_rdata;
   logic [3:0]  pirq_lvl = '0;
   logic [15:0] irq_out;
   logic [7:0]  slot_devfn = '0;
   logic [1:0]  slot_pin = '0;
   logic [1:0]  slot_line;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   int rt [4];
   logic [3:0] lv;

   always #5 clk = ~clk;

   pirq_router uut (
      .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .cfg_rd_idx(cfg_rd_idx), .cfg_rdata(cfg_rdata),
      .pirq_lvl(pirq_lvl), .irq_out(irq_out), .slot_devfn(slot_devfn),
      .slot_pin(slot_pin), .slot_line(slot_line)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] model();
      logic [15:0] v = '0;
      for (int i = 0; i < 4; i++)
         if (rt[i] < 16 && lv[i]) v[rt[i]] = 1'b1;
      return v;
   endfunction

   task automatic wr_route(input int i, input int v);
      cfg_wr = 1'b1; cfg_idx = 2'(i); cfg_wdata = 8'(v);
      rt[i] = v;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic set_lvl(input logic [3:0] v);
      pirq_lvl = v; lv = v;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 4; i++) rt[i] = 8'h80;
      lv = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      check("R1 irq", 32'(irq_out), 32'h0);
      for (int i = 0; i < 4; i++) begin
         cfg_rd_idx = 2'(i); #1;
         check("R1 route", 32'(cfg_rdata), 32'h80);
      end
      // R4 unrouted lines have no effect
      set_lvl(4'hF);
      check("R4 reset unrouted", 32'(irq_out), 32'h0);
      set_lvl(4'h0);
      // R3 sweep of every line to every output
      for (int i = 0; i < 4; i++) begin
         for (int t = 0; t < 16; t++) begin
            wr_route(i, t);
            set_lvl(4'(1 << i));
            check("R3 raise", 32'(irq_out), 32'(model()));
            set_lvl(4'h0);
            check("R3 lower", 32'(irq_out), 32'h0);
         end
         wr_route(i, 8'h80);
      end
      // R4 disabled values
      foreach (rt[k]) rt[k] = rt[k];
      for (int v = 16; v < 256; v += 37) begin
         wr_route(2, v);
         set_lvl(4'h4);
         check("R4 disabled", 32'(irq_out), 32'h0);
         set_lvl(4'h0);
         check("R4 disabled low", 32'(irq_out), 32'h0);
      end
      wr_route(2, 255);
      set_lvl(4'h4);
      check("R4 value 255", 32'(irq_out), 32'h0);
      set_lvl(4'h0);
      // R5 all lines share output 11
      for (int i = 0; i < 4; i++) wr_route(i, 11);
      for (int m = 0; m < 16; m++) begin
         set_lvl(4'(m));
         check("R5 shared", 32'(irq_out), 32'(model()));
      end
      set_lvl(4'hF);
      set_lvl(4'h8);
      check("R5 last holder", 32'(irq_out), 32'h0800);
      set_lvl(4'h0);
      check("R5 release", 32'(irq_out), 32'h0);
      // R6 re-steer a held line
      for (int i = 0; i < 4; i++) wr_route(i, 8'h80);
      wr_route(0, 3);
      set_lvl(4'h1);
      check("R6 before", 32'(irq_out), 32'h0008);
      wr_route(0, 9);
      check("R6 after", 32'(irq_out), 32'h0200);
      wr_route(0, 8'h90);
      check("R6 disabled by write", 32'(irq_out), 32'h0);
      wr_route(0, 3);
      check("R6 reconnect", 32'(irq_out), 32'h0008);
      // R9 hold
      repeat (3) @(negedge clk);
      check("R9 hold", 32'(irq_out), 32'h0008);
      set_lvl(4'h0);
      // R2 / R7 readback
      wr_route(0, 8'h85);
      wr_route(1, 8'h0E);
      wr_route(2, 8'hC1);
      wr_route(3, 8'h07);
      wr_route(1, 8'hFF);
      for (int i = 0; i < 4; i++) begin
         cfg_rd_idx = 2'(i); #1;
         check(i == 1 ? "R2 readback" : "R7 others kept", 32'(cfg_rdata), 32'(rt[i]));
      end
      // R3 mixed routing
      wr_route(0, 5); wr_route(1, 5); wr_route(2, 12); wr_route(3, 0);
      for (int m = 0; m < 16; m++) begin
         set_lvl(4'(m));
         check("R3 mixed", 32'(irq_out), 32'(model()));
      end
      set_lvl(4'h0);
      // R8 exhaustive slot lookup
      for (int d = 0; d < 256; d++) begin
         for (int p = 0; p < 4; p++) begin
            slot_devfn = 8'(d); slot_pin = 2'(p); #1;
            check("R8 slot", 32'(slot_line), 32'((p + (d >> 3) - 1) & 3));
         end
      end
      @(negedge clk);
      finish_run();
   end
endmodule